// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip that follows the 1149.1 boundary-scan standard. It is driven only by the test clock and the mode-select line, and it has no dedicated test reset pin. A power-on reset puts it into the Test-Logic-Reset state, and afterwards holding the mode-select line high for five clock edges brings it back there from any state. It holds a 3-bit instruction and, based on that instruction, places one data register between the serial input and the serial output. The data register is a single-bit bypass stage, a 32-bit identification word, or a boundary chain of configurable length.

The boundary chain captures a generic vector of sampled pin levels. Chain cells that have no pin behind them capture a constant 1. The chain presents its update stage as a vector of pin drive values. Two decoded controls go to the functional I/O ring: one hands the pins to the scan chain, and the other forces every functional output to high impedance. The serial input and the mode select are sampled on the rising test-clock edge. The serial output and its enable change on the falling edge.

Top module: `scan_tap_ctrl`

## Requirements
- R1: Instruction decode selects the data register. Codes 000 (external test), 010 (high-Z sample) and 100 (sample/preload) select the boundary chain. Code 001 selects the identification register. Codes 011, 101, 110 and 111 all select the one-bit bypass stage, which captures 0 and delays the serial input by one shift.
- R2: In Capture-DR under code 001, the identification register loads a 32-bit word whose bits 11:0 are 0x1B3 (bit 0 = 1) and whose bits 31:12 come from a parameter. It shifts out LSB first.
- R3: Capture-IR loads instruction shift bits [1:0] with 01 and bit 2 with 0, so the first three bits shifted out are 1, 0, 0. The instruction is shifted in LSB first.
- R4: Power-on reset and every entry into Test-Logic-Reset make 001 the active instruction.
- R5: Five consecutive rising edges with mode select high reach Test-Logic-Reset from any state. Four edges do not cancel the active instruction.
- R6: A shifted instruction becomes active only on leaving Update-IR. Until then the decoded outputs keep the previous instruction.
- R7: Mode select and serial input are sampled on the rising edge, and the serial output changes on the falling edge. `tdo_oe` is high only while the controller is in Shift-DR or Shift-IR.
- R8: `force_hiz` is high exactly while 010 is the active instruction.
- R9: Boundary cell j captures `pin_sample[j]` for j < PIN_CNT and captures 1 for every other cell.
- R10: On leaving Update-DR under a boundary-chain instruction, `pin_drive[j]` takes boundary cell j. Under any other instruction, `pin_drive` does not change. `scan_owns_pins` is high exactly while 000 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_oe | output | 1 | Serial output driver enable |
| pin_sample | input | PIN_CNT | Levels sampled from the functional pins |
| pin_drive | output | PIN_CNT | Update stage of the boundary chain |
| scan_owns_pins | output | 1 | External test active: pins driven from `pin_drive` |
| force_hiz | output | 1 | High-Z sample active: functional outputs off |

## Verification
A corrupted controller state shows up within one falling edge as a wrong `tdo_oe` value or a serial stream of the wrong length. A wrong active instruction appears at the next Update-IR exit, on `force_hiz` and `scan_owns_pins`. A wrong capture value is visible in the first bits shifted out of Shift-DR. Every one of the eight instruction codes is therefore loaded and followed by a longer data scan. Each scan compares both the captured prefix and the delayed tail of the input stream, which exposes both the capture content and the register length.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_CHAIN} dr_sel_e;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT  = 3'b001;
  localparam logic [IR_W-1:0] OP_HIZSMP = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;
  localparam logic [11:0] ID_FIXED_LOW = 12'h1B3;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_RESET:  return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      default:   return m ? ST_SEL_DR : ST_IDLE;
    endcase
  endfunction

  function automatic dr_sel_e decode_sel(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_HIZSMP, OP_SAMPLE: return DR_CHAIN;
      OP_IDENT:                        return DR_IDENT;
      default:                         return DR_BYPASS;
    endcase
  endfunction

  function automatic logic [31:0] make_ident(input logic [19:0] upper);
    return {upper, ID_FIXED_LOW};
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state,
  output logic       to_reset
);
  tap_state_e nxt;

  always_comb begin
    nxt      = tap_next(state, tms);
    to_reset = (nxt == ST_RESET);
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= ST_RESET;
    else        state <= nxt;
  end
endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  tap_state_e      state,
  input  logic            to_reset,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_tdo,
  output dr_sel_e         sel,
  output logic            scan_owns_pins,
  output logic            force_hiz
);
  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sh <= '0;
    end else if (state == ST_CAP_IR) begin
      ir_sh <= IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                  ir_q <= OP_IDENT;
    else if (to_reset)           ir_q <= OP_IDENT;
    else if (state == ST_UPD_IR) ir_q <= ir_sh;
  end

  always_comb begin
    ir_tdo         = ir_sh[0];
    sel            = decode_sel(ir_q);
    scan_owns_pins = (ir_q == OP_EXTEST);
    force_hiz      = (ir_q == OP_HIZSMP);
  end
endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN  = 12,
  parameter int          PIN_CNT  = 10,
  parameter logic [19:0] ID_UPPER = 20'h5A3C7
) (
  input  logic               tck,
  input  logic               por_n,
  input  tap_state_e         state,
  input  dr_sel_e            sel,
  input  logic               tdi,
  input  logic [PIN_CNT-1:0] pin_sample,
  output logic               dr_tdo,
  output logic [PIN_CNT-1:0] pin_drive,
  output logic               upd_chain
);
  localparam logic [31:0] ID_VAL = make_ident(ID_UPPER);

  logic               byp_q;
  logic [31:0]        id_sh;
  logic [BSR_LEN-1:0] bsr_sh;
  logic [BSR_LEN-1:0] bsr_cap;

  for (genvar j = 0; j < BSR_LEN; j++) begin : g_cell
    if (j < PIN_CNT) begin : g_pin
      assign bsr_cap[j] = pin_sample[j];
    end else begin : g_fill
      assign bsr_cap[j] = 1'b1;
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp_q  <= 1'b0;
      id_sh  <= '0;
      bsr_sh <= '0;
    end else if (state == ST_CAP_DR) begin
      case (sel)
        DR_IDENT: id_sh  <= ID_VAL;
        DR_CHAIN: bsr_sh <= bsr_cap;
        default:  byp_q  <= 1'b0;
      endcase
    end else if (state == ST_SH_DR) begin
      case (sel)
        DR_IDENT: id_sh  <= {tdi, id_sh[31:1]};
        DR_CHAIN: bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
        default:  byp_q  <= tdi;
      endcase
    end
  end

  assign upd_chain = (state == ST_UPD_DR) && (sel == DR_CHAIN);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)         pin_drive <= '0;
    else if (upd_chain) pin_drive <= bsr_sh[PIN_CNT-1:0];
  end

  always_comb begin
    case (sel)
      DR_IDENT: dr_tdo = id_sh[0];
      DR_CHAIN: dr_tdo = bsr_sh[0];
      default:  dr_tdo = byp_q;
    endcase
  end
endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN  = 12,
  parameter int          PIN_CNT  = 10,
  parameter logic [19:0] ID_UPPER = 20'h5A3C7
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [PIN_CNT-1:0] pin_sample,
  output logic [PIN_CNT-1:0] pin_drive,
  output logic               scan_owns_pins,
  output logic               force_hiz
);
  tap_state_e      st;
  logic            to_reset;
  logic [IR_W-1:0] ir_q;
  logic            ir_tdo;
  logic            dr_tdo;
  logic            upd_chain;
  dr_sel_e         sel;
  logic            in_shift;
  logic            tdo_next;

  scan_tap_fsm u_fsm (
    .tck(tck), .por_n(por_n), .tms(tms), .state(st), .to_reset(to_reset)
  );

  scan_tap_ir u_ir (
    .tck(tck), .por_n(por_n), .state(st), .to_reset(to_reset), .tdi(tdi),
    .ir_q(ir_q), .ir_tdo(ir_tdo), .sel(sel),
    .scan_owns_pins(scan_owns_pins), .force_hiz(force_hiz)
  );

  scan_tap_dr #(.BSR_LEN(BSR_LEN), .PIN_CNT(PIN_CNT), .ID_UPPER(ID_UPPER)) u_dr (
    .tck(tck), .por_n(por_n), .state(st), .sel(sel), .tdi(tdi),
    .pin_sample(pin_sample), .dr_tdo(dr_tdo), .pin_drive(pin_drive),
    .upd_chain(upd_chain)
  );

  always_comb begin
    in_shift = (st == ST_SH_DR) || (st == ST_SH_IR);
    tdo_next = (st == ST_SH_IR) ? ir_tdo : dr_tdo;
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= in_shift ? tdo_next : 1'b0;
      tdo_oe <= in_shift;
    end
  end
endmodule

// File: rtl/scan_tap_checker.sv
module scan_tap_checker
  import scan_tap_pkg::*;
#(
  parameter int PIN_CNT = 10
) (
  input logic               tck,
  input logic               por_n,
  input logic               tms,
  input tap_state_e         st,
  input logic               to_reset,
  input logic [IR_W-1:0]    ir_q,
  input logic               upd_chain,
  input logic               tdo_oe,
  input logic               force_hiz,
  input logic               scan_owns_pins,
  input logic [PIN_CNT-1:0] pin_drive
);
  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)          ones_cnt <= '0;
    else if (!tms)       ones_cnt <= '0;
    else if (ones_cnt < 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  a_r5_five_ones_reset: assert property (@(posedge tck) disable iff (!por_n)
    (ones_cnt == 3'd5) |-> (st == ST_RESET));

  a_r4_reset_holds_ident: assert property (@(posedge tck) disable iff (!por_n)
    (st == ST_RESET) |-> (ir_q == OP_IDENT));

  a_r6_ir_only_at_update: assert property (@(posedge tck) disable iff (!por_n)
    (st != ST_UPD_IR && !to_reset) |=> $stable(ir_q));

  a_r7_oe_only_shift: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe |-> (st == ST_SH_DR || st == ST_SH_IR));

  a_r8_hiz_excludes_extest: assert property (@(posedge tck) disable iff (!por_n)
    force_hiz |-> !scan_owns_pins);

  a_r10_drive_holds: assert property (@(posedge tck) disable iff (!por_n)
    !upd_chain |=> $stable(pin_drive));
endmodule

bind scan_tap_ctrl scan_tap_checker #(.PIN_CNT(PIN_CNT)) u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .st(st), .to_reset(to_reset),
  .ir_q(ir_q), .upd_chain(upd_chain), .tdo_oe(tdo_oe), .force_hiz(force_hiz),
  .scan_owns_pins(scan_owns_pins), .pin_drive(pin_drive)
);

// File: tb/scan_tap_ctrl_tb.sv
`timescale 1ns/1ps
module scan_tap_ctrl_tb;
  localparam int BSR = 8;
  localparam int PINS = 6;
  localparam logic [19:0] IDU = 20'h3C5A9;
  localparam int NSH = 40;

  logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, scan_owns_pins, force_hiz;
  logic [PINS-1:0] pin_sample = '0, pin_drive;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #2 tck = ~tck;

  scan_tap_ctrl #(.BSR_LEN(BSR), .PIN_CNT(PINS), .ID_UPPER(IDU)) u_dut (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_sample(pin_sample), .pin_drive(pin_drive),
    .scan_owns_pins(scan_owns_pins), .force_hiz(force_hiz)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic seen, output logic oe_seen);
    @(negedge tck); #1;
    seen = tdo; oe_seen = tdo_oe;
    tms = m; tdi = d;
  endtask

  task automatic peek();
    @(posedge tck); #0.5;
  endtask

  task automatic ir_scan(input logic [2:0] op, input logic [2:0] prev_op);
    logic s, o;
    logic [2:0] out;
    step(1, 0, s, o); step(1, 0, s, o); step(0, 0, s, o); step(0, 0, s, o);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, op[i], out[i], o);
      if (i == 0) check("R7 oe in Shift-IR", {63'd0, o}, 64'd1);
    end
    check("R3 capture-IR pattern", {61'd0, out}, 64'd1);
    peek();
    check("R6 hiz held before Update-IR", {63'd0, force_hiz}, {63'd0, prev_op == 3'b010});
    step(1, 0, s, o);
    check("R7 oe low after Shift-IR", {63'd0, o}, 64'd0);
    step(0, 0, s, o);
    peek();
  endtask

  task automatic dr_scan(input logic [63:0] din, output logic [63:0] dout);
    logic s, o;
    dout = '0;
    step(1, 0, s, o); step(0, 0, s, o); step(0, 0, s, o);
    for (int i = 0; i < NSH; i++) begin
      step(i == NSH - 1, din[i], dout[i], o);
      if (i == 0) check("R7 oe in Shift-DR", {63'd0, o}, 64'd1);
    end
    step(1, 0, s, o);
    check("R7 oe low in Exit1-DR", {63'd0, o}, 64'd0);
    step(0, 0, s, o);
    peek();
  endtask

  function automatic int reg_len(input logic [2:0] op);
    if (op == 3'b000 || op == 3'b010 || op == 3'b100) return BSR;
    if (op == 3'b001) return 32;
    return 1;
  endfunction

  function automatic logic [63:0] cap_val(input logic [2:0] op, input logic [PINS-1:0] ps);
    if (op == 3'b000 || op == 3'b010 || op == 3'b100) return 64'({{(BSR - PINS){1'b1}}, ps});
    if (op == 3'b001) return {32'd0, IDU, 12'h1B3};
    return 64'd0;
  endfunction

  function automatic logic [63:0] expect_out(input logic [2:0] op, input logic [PINS-1:0] ps,
                                              input logic [63:0] din);
    logic [63:0] r = '0;
    int L = reg_len(op);
    logic [63:0] c = cap_val(op, ps);
    for (int i = 0; i < NSH; i++) r[i] = (i < L) ? c[i] : din[i - L];
    return r;
  endfunction

  initial begin
    logic [63:0] din, dout;
    logic [2:0] prev;
    logic [PINS-1:0] drv_before;
    logic s, o;
    #9 por_n = 1'b1;
    peek();
    check("R4 reset hiz", {63'd0, force_hiz}, 64'd0);
    check("R4 reset extest", {63'd0, scan_owns_pins}, 64'd0);
    check("R7 reset oe", {63'd0, tdo_oe}, 64'd0);
    step(0, 0, s, o);
    din = 64'h0F1E_2D3C_4B5A_6978;
    dr_scan(din, dout);
    check("R2 R4 ident after power-up", dout & 64'hFF_FFFF_FFFF, expect_out(3'b001, pin_sample, din));
    prev = 3'b001;
    for (int op = 0; op < 8; op++) begin
      logic [2:0] opc = 3'(op);
      pin_sample = PINS'(op * 11 + 5);
      ir_scan(opc, prev);
      check("R8 hiz decode", {63'd0, force_hiz}, {63'd0, opc == 3'b010});
      check("R10 extest decode", {63'd0, scan_owns_pins}, {63'd0, opc == 3'b000});
      drv_before = pin_drive;
      din = 64'hC3A5_96F0_1E2D_7B48 ^ {8{5'd0, opc}};
      dr_scan(din, dout);
      check("R1 R2 R9 scan stream", dout & 64'hFF_FFFF_FFFF, expect_out(opc, pin_sample, din));
      if (reg_len(opc) == BSR)
        check("R10 update to pins", 64'(pin_drive), 64'(din[NSH - BSR +: PINS]));
      else
        check("R10 pins unchanged", 64'(pin_drive), 64'(drv_before));
      prev = opc;
    end
    ir_scan(3'b010, prev);
    step(1, 0, s, o); step(0, 0, s, o); step(0, 0, s, o);
    for (int k = 0; k < 4; k++) step(1, 0, s, o);
    peek();
    check("R5 four ones keep instruction", {63'd0, force_hiz}, 64'd1);
    step(1, 0, s, o);
    peek();
    check("R5 fifth one resets", {63'd0, force_hiz}, 64'd0);
    step(0, 0, s, o);
    din = 64'h1234_5678_9ABC_DEF0;
    dr_scan(din, dout);
    check("R4 ident after reset entry", dout & 64'hFF_FFFF_FFFF, expect_out(3'b001, pin_sample, din));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule